// File: doc/BRIEF.md
# Reversible Minterm Decoder (AND Plane)

This block forms the AND plane of a reversible programmable logic array. It expands N input variables into the full set of 2^N minterms. It is assembled only from one-to-one reversible gates: there is no ordinary AND or inverter logic in the expansion path. A 4-in/4-out reversible decoder gate takes two constant-zero inputs and produces the four minterms of the two low variables. For each further variable, a rank of controlled-swap gates is added. Each gate in a rank splits one existing minterm into the half where the new variable is 0 and the half where it is 1. Each of those gates consumes one constant-zero line.

The control copy of each swap gate feeds the control of the next gate in its rank. Only the last copy in a rank is left unused, and that copy is reported as a garbage line. The network itself is combinational. Its minterm vector and garbage lines are captured in one output register stage. The block also reports, as constant ports, its gate count, garbage count and constant-input count, and these follow closed-form expressions in N. A downstream OR plane uses the registered minterm vector.

Top module: `rpla_and_plane`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `minterm` and `garbage` are cleared to all zeros at that edge.
- R2: One clock edge after `vars` is sampled with `rst_n` high, `minterm` bit i is 1 exactly when i equals the unsigned value of `vars`, with `vars[0]` as weight 1. All other bits are 0.
- R3: For every one of the 2^N combinations of `vars`, exactly one bit of `minterm` is high.
- R4: Garbage bit g (0 <= g < N-2) carries the registered value of `vars[g+2]`, which is the final control copy of the rank that adds that variable. When N is 2, the single `garbage` bit is always 0.
- R5: `gate_count` equals 2^N - 3: one base decoder gate plus 2^k swap gates for each k from 2 to N-1.
- R6: `garbage_count` equals N - 2. The base decoder gate contributes no garbage.
- R7: `const_count` equals 2^N - 2: two constant-zero lines for the base gate and one for each swap gate. This gives 6 when N is 3.
- R8: If `rst_n` is low in the same cycle that `vars` changes, that edge leaves the outputs at zero. The first edge with `rst_n` high captures the held `vars`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vars | input | N | Input variables, `vars[0]` is weight 1 |
| minterm | output | 2^N | Registered minterm vector |
| garbage | output | max(N-2,1) | Registered unused control copies, one per rank |
| gate_count | output | N+1 | Number of reversible gates (2^N - 3) |
| garbage_count | output | N+1 | Number of garbage lines (N - 2) |
| const_count | output | N+1 | Number of constant-zero inputs (2^N - 2) |

## Verification
A reset and a change of the input variables can fall in the same cycle. The bench provokes this by pulling `rst_n` low on the same falling edge that it drives a new `vars` value. It then judges that the following edge shows zero minterms and zero garbage rather than the new minterm. After releasing reset with `vars` held, it expects exactly the one-hot code for that value, with the garbage bits matching the upper variables. Exhaustive sweeps at N = 3 and N = 4 then confirm the one-hot rule and the bit positions.

// File: rtl/rpla_pkg.sv
// Package: closed-form resource counts for the reversible AND plane.
// Assumes n >= 2. All functions are constant-foldable.
package rpla_pkg;

    // Total reversible gates: one base decoder plus 2^k swap gates per rank.
    function automatic int gate_total(input int n);
        return (1 << n) - 3;
    endfunction

    // Unused outputs: one control copy per rank, none from the base decoder.
    function automatic int garbage_total(input int n);
        return n - 2;
    endfunction

    // Constant-zero inputs: two for the base gate, one per swap gate.
    function automatic int const_total(input int n);
        return (1 << n) - 2;
    endfunction

endpackage

// File: rtl/rev_fredkin.sv
// Controlled-swap reversible gate (3 in / 3 out).
// The control passes straight through. The two data lines trade places when the
// control is 1. The mapping is a bijection and preserves the number of ones.
module rev_fredkin (
    input  logic c,
    input  logic p,
    input  logic q,
    output logic c_o,
    output logic p_o,
    output logic q_o
);

    // Purpose: conditional exchange of the data pair.
    always_comb begin
        c_o = c;
        p_o = c ? q : p;
        q_o = c ? p : q;
    end

    // Guard: a swap never creates or destroys a one (supports R2).
    always_comb begin
        assert_fredkin_conserve_R2: assert ($countones({c_o, p_o, q_o}) == $countones({c, p, q}));
    end

endmodule

// File: rtl/rev_dec2.sv
// Base reversible 2-to-4 decoder gate (4 in / 4 out).
// It is built as a cascade of Toffoli, CNOT and NOT steps, so the whole gate is a
// bijection on its four lines. With k0 = k1 = 0, the outputs are
// y[0]=a'b', y[1]=a'b, y[2]=ab', y[3]=ab. Every output is used, so there is no garbage.
module rev_dec2 (
    input  logic       a,
    input  logic       b,
    input  logic       k0,
    input  logic       k1,
    output logic [3:0] y
);

    logic l0_s1, l1_s1, l2_s1, l3_s1;
    logic l2_s2, l3_s2;
    logic l1_s3;
    logic l0_s4, l0_s5;

    // Purpose: step 1, Toffoli onto line 2 (k0 ^ a&b); lines 0, 1 and 3 pass.
    always_comb begin
        l0_s1 = a;
        l1_s1 = b;
        l2_s1 = k0 ^ (a & b);
        l3_s1 = k1;
    end

    // Purpose: step 2, CNOT of line 0 into line 3, then CNOT of line 2 into line 3.
    always_comb begin
        l2_s2 = l2_s1;
        l3_s2 = (l3_s1 ^ l0_s1) ^ l2_s1;
    end

    // Purpose: step 3, CNOT of line 2 into line 1 (b ^ ab = a'b).
    always_comb begin
        l1_s3 = l1_s1 ^ l2_s2;
    end

    // Purpose: step 4, CNOT of line 1 into line 0 (a ^ a'b = a|b), then NOT.
    always_comb begin
        l0_s4 = l0_s1 ^ l1_s3;
        l0_s5 = ~l0_s4;
    end

    // Purpose: route the final lines to the minterm order.
    always_comb begin
        y = {l2_s2, l3_s2, l1_s3, l0_s5};
    end

    // Guard: with constant-zero ancillas exactly one minterm is high (R3).
    always_comb begin
        if (k0 == 1'b0 && k1 == 1'b0) begin
            assert_dec2_onehot_R3: assert ($onehot(y));
        end
    end

endmodule

// File: rtl/rev_split_rank.sv
// One expansion rank: adds variable x to a set of M = 2^K minterms.
// Gate j takes control from the previous gate's control copy, data m_in[j], and a
// constant 0. It yields x'·m (low half) and x·m (high half). Only the last control
// copy is left over, and it is returned as ctl_tail.
module rev_split_rank #(
    parameter int K = 2,
    localparam int M = 1 << K
) (
    input  logic           x,
    input  logic [M-1:0]   m_in,
    output logic [2*M-1:0] m_out,
    output logic           ctl_tail
);

    logic [M:0] ctl_chain;

    // Purpose: feed the new variable into the head of the control chain.
    always_comb begin
        ctl_chain[0] = x;
    end

    for (genvar j = 0; j < M; j++) begin : g_gate
        rev_fredkin u_fr (
            .c   (ctl_chain[j]),
            .p   (m_in[j]),
            .q   (1'b0),
            .c_o (ctl_chain[j+1]),
            .p_o (m_out[j]),
            .q_o (m_out[j+M])
        );
    end

    // Purpose: expose the unused final control copy as garbage.
    always_comb begin
        ctl_tail = ctl_chain[M];
    end

    // Guard: splitting preserves the number of active minterms (R3).
    always_comb begin
        assert_rank_split_R3: assert ($countones(m_out) == $countones(m_in));
    end

endmodule

// File: rtl/rpla_and_plane.sv
// Reversible AND plane: N variables to 2^N minterms, plus garbage lines and counts.
// Assumes N >= 2. The base decoder covers vars[1:0]. Rank k (k = 2..N-1) adds vars[k].
// The stage-k minterm set sits at offset 2^k of a flat tree bus.
// Outputs are registered once, with a synchronous active-low reset.
module rpla_and_plane #(
    parameter int N = 3,
    localparam int NM = 1 << N,
    localparam int GW = (N > 2) ? N - 2 : 1,
    localparam int CW = N + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  vars,
    output logic [NM-1:0] minterm,
    output logic [GW-1:0] garbage,
    output logic [CW-1:0] gate_count,
    output logic [CW-1:0] garbage_count,
    output logic [CW-1:0] const_count
);

    logic [2*NM-1:0] tree;
    logic [GW-1:0]   garb_next;

    // Purpose: the unused low slice of the tree bus is tied off.
    assign tree[3:0] = 4'b0000;

    rev_dec2 u_base (
        .a  (vars[1]),
        .b  (vars[0]),
        .k0 (1'b0),
        .k1 (1'b0),
        .y  (tree[7:4])
    );

    if (N > 2) begin : g_ranks
        for (genvar k = 2; k < N; k++) begin : g_rank
            rev_split_rank #(.K(k)) u_rank (
                .x        (vars[k]),
                .m_in     (tree[(1 << k) +: (1 << k)]),
                .m_out    (tree[(1 << (k+1)) +: (1 << (k+1))]),
                .ctl_tail (garb_next[k-2])
            );
        end
    end else begin : g_no_rank
        assign garb_next = '0;
    end

    // Purpose: capture the minterm vector and garbage lines; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            minterm <= '0;
            garbage <= '0;
        end else begin
            minterm <= tree[NM +: NM];
            garbage <= garb_next;
        end
    end

    // Purpose: constant resource-count ports from the closed-form expressions.
    assign gate_count    = CW'(rpla_pkg::gate_total(N));
    assign garbage_count = CW'(rpla_pkg::garbage_total(N));
    assign const_count   = CW'(rpla_pkg::const_total(N));

    // R1, R8: the first edge after reset leaves the outputs cleared.
    property p_reset_clear;
        @(posedge clk) disable iff (!rst_n) !$past(rst_n) |-> (minterm == '0 && garbage == '0);
    endproperty
    assert_reset_clear_R1: assert property (p_reset_clear);

    // R3: the registered vector is one-hot in steady operation.
    property p_onehot;
        @(posedge clk) disable iff (!rst_n) $past(rst_n) |-> $onehot(minterm);
    endproperty
    assert_onehot_R3: assert property (p_onehot);

    // R2: the active bit sits at the index given by the sampled variables.
    property p_index;
        @(posedge clk) disable iff (!rst_n) $past(rst_n) |-> minterm[$past(vars)];
    endproperty
    assert_index_R2: assert property (p_index);

    // R4: the garbage lines carry the upper variables of the previous cycle.
    if (N > 2) begin : g_garb_chk
        property p_garb;
            @(posedge clk) disable iff (!rst_n) $past(rst_n) |-> garbage == $past(vars[N-1:2]);
        endproperty
        assert_garbage_track_R4: assert property (p_garb);
    end

endmodule

// File: tb/rpla_and_plane_test.sv
// Directed bench: one task per scenario, for N = 3 (uut) and N = 4 (uut4).
module rpla_and_plane_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  vars3 = '0;
    logic [3:0]  vars4 = '0;
    logic [7:0]  mt3;
    logic [15:0] mt4;
    logic [0:0]  gb3;
    logic [1:0]  gb4;
    logic [3:0]  gc3, gbc3, cc3;
    logic [4:0]  gc4, gbc4, cc4;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    rpla_and_plane #(.N(3)) uut (
        .clk(clk), .rst_n(rst_n), .vars(vars3), .minterm(mt3), .garbage(gb3),
        .gate_count(gc3), .garbage_count(gbc3), .const_count(cc3)
    );

    rpla_and_plane #(.N(4)) uut4 (
        .clk(clk), .rst_n(rst_n), .vars(vars4), .minterm(mt4), .garbage(gb4),
        .gate_count(gc4), .garbage_count(gbc4), .const_count(cc4)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R1: outputs cleared while reset is held.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        vars3 = 3'd6;
        vars4 = 4'd9;
        @(negedge clk);
        check(mt3 == 0, "R1 minterm n3", mt3, 0);
        check(gb3 == 0, "R1 garbage n3", gb3, 0);
        check(mt4 == 0, "R1 minterm n4", mt4, 0);
        check(gb4 == 0, "R1 garbage n4", gb4, 0);
        rst_n = 1'b1;
    endtask

    // R2, R3, R4: exhaustive sweep at N = 3.
    task automatic t_sweep3();
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            vars3 = 3'(v);
            @(negedge clk);
            check(mt3 == (8'd1 << v), "R2 index n3", mt3, 8'd1 << v);
            check($countones(mt3) == 1, "R3 onehot n3", $countones(mt3), 1);
            check(gb3[0] == v[2], "R4 garbage n3", gb3, v[2]);
        end
    endtask

    // R2, R3, R4: exhaustive sweep at N = 4.
    task automatic t_sweep4();
        for (int v = 15; v >= 0; v--) begin
            @(negedge clk);
            vars4 = 4'(v);
            @(negedge clk);
            check(mt4 == (16'd1 << v), "R2 index n4", mt4, 16'd1 << v);
            check($countones(mt4) == 1, "R3 onehot n4", $countones(mt4), 1);
            check(gb4 == 2'(v >> 2), "R4 garbage n4", gb4, v >> 2);
        end
    endtask

    // R5, R6, R7: closed-form counts.
    task automatic t_counts();
        check(gc3 == 4'd5, "R5 gates n3", gc3, 5);
        check(gc4 == 5'd13, "R5 gates n4", gc4, 13);
        check(gbc3 == 4'd1, "R6 garbage count n3", gbc3, 1);
        check(gbc4 == 5'd2, "R6 garbage count n4", gbc4, 2);
        check(cc3 == 4'd6, "R7 constants n3", cc3, 6);
        check(cc4 == 5'd14, "R7 constants n4", cc4, 14);
    endtask

    // R8: reset asserted in the same cycle as a new input value.
    task automatic t_collide();
        @(negedge clk);
        vars3 = 3'd1;
        vars4 = 4'd2;
        @(negedge clk);
        vars3 = 3'd5;
        vars4 = 4'd12;
        rst_n = 1'b0;
        @(negedge clk);
        check(mt3 == 0, "R8 held in reset n3", mt3, 0);
        check(mt4 == 0 && gb4 == 0, "R8 held in reset n4", mt4, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mt3 == 8'h20, "R8 capture after release n3", mt3, 8'h20);
        check(gb3 == 1'b1, "R8 garbage after release n3", gb3, 1);
        check(mt4 == 16'h1000, "R8 capture after release n4", mt4, 16'h1000);
        check(gb4 == 2'd3, "R8 garbage after release n4", gb4, 3);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_sweep3();
        t_sweep4();
        t_counts();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule